// File: doc/BRIEF.md
# Adaptive Voltage Window Monitor

This block watches a supply level, given as an 8-bit input from a sensor, and compares it against a programmable window. The window has a floor and a ceiling. When the level reaches the floor, a sticky minimum flag is raised. When the level reaches the ceiling, a sticky maximum flag is raised. Either flag drives a single interrupt line.

Software programs the block through a small register port, which has a single-cycle write strobe and a combinational read. A control word holds the following:
- the monitor enable;
- the two interrupt enables;
- a gate bit, which a voltage-change routine drops while a change is in progress and raises again afterwards;
- a nominal level field;
- a derived lower field.

Writing the retarget register recentres the window around a new nominal level. The nominal field takes the written level, and the lower field takes that level minus four. A software routine acknowledges an interrupt by writing its enable bit to zero and then back to one. Writing the status register does not clear anything.

Top module: `avs_limit_monitor`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `adapt_on` is 0.
- R2: A write to the control register (offset 0x20) stores bit 0 (monitor enable), bit 1 (minimum interrupt enable), bit 2 (maximum interrupt enable), bits [15:10] (lower field), bits [22:17] (nominal field) and bit 27 (gate). Reads return only these bits, so the readback mask is 0x087EFC07. `adapt_on` follows bit 27.
- R3: A write to the limit register (offset 0x24) stores the minimum in bits [7:0] and the maximum in bits [23:16]. All other bits of this register read zero.
- R4: A write to the retarget register (offset 0x28) sets control bits [22:17] to wdata[5:0] and control bits [15:10] to (wdata[5:0] − 4) modulo 64. All other control bits keep their values. The retarget register reads zero.
- R5: The minimum flag sets at a clock edge when all of the following hold: control bits 0 and 27 are both 1, `level_in` is less than or equal to the minimum, and bit 1 is 1 after that edge.
- R6: The maximum flag sets at a clock edge when all of the following hold: control bits 0 and 27 are both 1, `level_in` is greater than or equal to the maximum, and bit 2 is 1 after that edge.
- R7: While bit 0 or bit 27 is 0, neither flag can become set, whatever the level.
- R8: A flag stays set after the level returns inside the window. It also stays set across writes that keep its enable bit at 1.
- R9: A control write whose enable bit for a flag is 0 clears that flag at that edge. Setting the bit back to 1 does not set the flag again unless the limit condition is met again.
- R10: The status register (offset 0x10) reads the minimum flag in bit 0 and the maximum flag in bit 1. Writes to the status register change nothing.
- R11: `irq` is 1 exactly when at least one flag is set together with its enable bit.
- R12: Reads from any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| level_in | input | 8 | Level reported by the sensor |
| irq | output | 1 | Interrupt request |
| adapt_on | output | 1 | Gate bit that permits adaptive operation |

## Verification
The hardest case to reach from the ports is a control write that lands on the same edge as a limit hit. Depending on the new enable bit, the flag must then either be cleared, be set for the first time, or be kept. A second hard case is the recentring write whose level is below four, where the lower field wraps. The random phase therefore issues control writes often. Its limits are drawn so that the random level crosses them frequently, and directed steps cover the wrap and a hit on the exact boundary.

// File: rtl/avs_limit_monitor.sv
module avs_limit_monitor #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STS_OFS = 'h10,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h20,
  parameter logic [ADDR_W-1:0] LIM_OFS = 'h24,
  parameter logic [ADDR_W-1:0] TGT_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        level_in,
  output logic              irq,
  output logic              adapt_on
);
  localparam logic [5:0] STEP_DOWN = 6'd4;

  logic mon_en, min_ie, max_ie, gate;
  logic [5:0] nom, low;
  logic [7:0] lim_min, lim_max;
  logic pend_min, pend_max;

  logic wr_ctl, wr_lim, wr_tgt;
  logic min_ie_d, max_ie_d, active;

  assign wr_ctl = bus_we && (bus_addr == CTL_OFS);
  assign wr_lim = bus_we && (bus_addr == LIM_OFS);
  assign wr_tgt = bus_we && (bus_addr == TGT_OFS);

  assign min_ie_d = wr_ctl ? bus_wdata[1] : min_ie;
  assign max_ie_d = wr_ctl ? bus_wdata[2] : max_ie;
  assign active   = mon_en & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en   <= 1'b0;
      min_ie   <= 1'b0;
      max_ie   <= 1'b0;
      gate     <= 1'b0;
      nom      <= '0;
      low      <= '0;
      lim_min  <= '0;
      lim_max  <= '0;
      pend_min <= 1'b0;
      pend_max <= 1'b0;
    end else begin
      if (wr_ctl) begin
        mon_en <= bus_wdata[0];
        min_ie <= bus_wdata[1];
        max_ie <= bus_wdata[2];
        low    <= bus_wdata[15:10];
        nom    <= bus_wdata[22:17];
        gate   <= bus_wdata[27];
      end else if (wr_tgt) begin
        nom <= bus_wdata[5:0];
        low <= bus_wdata[5:0] - STEP_DOWN;
      end
      if (wr_lim) begin
        lim_min <= bus_wdata[7:0];
        lim_max <= bus_wdata[23:16];
      end
      pend_min <= min_ie_d & (pend_min | (active & (level_in <= lim_min)));
      pend_max <= max_ie_d & (pend_max | (active & (level_in >= lim_max)));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      STS_OFS: bus_rdata[1:0] = {pend_max, pend_min};
      CTL_OFS: begin
        bus_rdata[0]     = mon_en;
        bus_rdata[1]     = min_ie;
        bus_rdata[2]     = max_ie;
        bus_rdata[15:10] = low;
        bus_rdata[22:17] = nom;
        bus_rdata[27]    = gate;
      end
      LIM_OFS: begin
        bus_rdata[7:0]   = lim_min;
        bus_rdata[23:16] = lim_max;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq      = (pend_min & min_ie) | (pend_max & max_ie);
  assign adapt_on = gate;

  // R9
  min_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !bus_wdata[1]) |=> !pend_min);

  // R8
  min_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_min && !(wr_ctl && !bus_wdata[1])) |=> pend_min);

  // R7
  max_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pend_max) |=> !pend_max);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(active));

  // R4
  tgt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgt |=> (low == nom - STEP_DOWN));
endmodule

// File: tb/avs_limit_monitor_bench.sv
module avs_limit_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0] level_in = '0;
  logic irq, adapt_on;

  localparam logic [11:0] A_STS = 12'h010, A_CTL = 12'h020, A_LIM = 12'h024, A_TGT = 12'h028;
  localparam logic [31:0] CTL_MASK = 32'h087E_FC07;
  localparam logic [31:0] LIM_MASK = 32'h00FF_00FF;

  int checks = 0, fails = 0;
  logic [31:0] m_ctl = '0, m_lim = '0;
  logic m_pmin = 1'b0, m_pmax = 1'b0;

  avs_limit_monitor u_avs_limit_monitor (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level_in(level_in),
    .irq(irq), .adapt_on(adapt_on));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      A_STS: return {30'd0, m_pmax, m_pmin};
      A_CTL: return m_ctl;
      A_LIM: return m_lim;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d,
                     input logic [7:0] lv, input bit rchk, input string req);
    logic [31:0] nctl;
    logic act;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; level_in = lv;
    #1;
    if (rchk && !we) check(req, bus_rdata, m_read(a));
    act = m_ctl[0] & m_ctl[27];
    nctl = m_ctl;
    if (we && a == A_CTL) nctl = d & CTL_MASK;
    else if (we && a == A_TGT)
      nctl = (m_ctl & ~32'h007E_FC00) | ({26'd0, d[5:0]} << 17) |
             ({26'd0, 6'(d[5:0] - 6'd4)} << 10);
    m_pmin = nctl[1] & (m_pmin | (act & (lv <= m_lim[7:0])));
    m_pmax = nctl[2] & (m_pmax | (act & (lv >= m_lim[23:16])));
    if (we && a == A_LIM) m_lim = d & LIM_MASK;
    m_ctl = nctl;
    @(posedge clk); #1;
    check("R11 irq", {31'd0, irq}, {31'd0, (m_pmin & m_ctl[1]) | (m_pmax & m_ctl[2])});
    check("R2 adapt_on", {31'd0, adapt_on}, {31'd0, m_ctl[27]});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [7:0] lv);
    cyc(1'b1, a, d, lv, 1'b0, "");
  endtask
  task automatic rd(input logic [11:0] a, input logic [7:0] lv, input string req);
    cyc(1'b0, a, 32'd0, lv, 1'b1, req);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    check("R1 ctl", bus_rdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 adapt_on", {31'd0, adapt_on}, 32'd0);
    rst_n = 1'b1;
    rd(A_CTL, 8'd0, "R1 ctl read");
    rd(A_LIM, 8'd0, "R1 lim read");
    rd(A_STS, 8'd0, "R1 sts read");
    // R2 readback mask
    wr(A_CTL, 32'hFFFF_FFFF, 8'd100);
    check("R2 mask", m_ctl, CTL_MASK);
    rd(A_CTL, 8'd100, "R2 ctl readback");
    // R3 limit fields
    wr(A_LIM, 32'hFFFF_FFFF, 8'd100);
    rd(A_LIM, 8'd100, "R3 lim readback");
    wr(A_CTL, 32'd0, 8'd100);
    // R4 retarget with wrap and normal
    wr(A_TGT, 32'd2, 8'd100);
    rd(A_CTL, 8'd100, "R4 wrap");
    check("R4 wrap field", m_ctl & 32'h007E_FC00, (32'd2 << 17) | (32'd62 << 10));
    wr(A_TGT, 32'hFFFF_FF28, 8'd100);
    rd(A_CTL, 8'd100, "R4 nominal 40");
    rd(A_TGT, 8'd100, "R4 tgt reads zero");
    // R5 min hit on boundary, R7 gate off
    wr(A_LIM, {8'd0, 8'd200, 8'd0, 8'd50}, 8'd100);
    wr(A_CTL, 32'h0000_0007, 8'd50);
    rd(A_STS, 8'd50, "R7 gate off no flag");
    wr(A_CTL, 32'h0800_0007, 8'd100);
    rd(A_STS, 8'd50, "R5 min at boundary");
    check("R5 min flag", {31'd0, m_pmin}, 32'd1);
    // R8 sticky
    rd(A_STS, 8'd100, "R8 sticky min");
    wr(A_CTL, 32'h0800_0007, 8'd100);
    rd(A_STS, 8'd100, "R8 sticky after write");
    // R10 status write ignored
    wr(A_STS, 32'd0, 8'd100);
    rd(A_STS, 8'd100, "R10 sts write ignored");
    // R9 clear and rearm
    wr(A_CTL, 32'h0800_0005, 8'd100);
    rd(A_STS, 8'd100, "R9 cleared");
    wr(A_CTL, 32'h0800_0007, 8'd100);
    rd(A_STS, 8'd100, "R9 rearm no set");
    // R6 max on boundary
    rd(A_STS, 8'd200, "R6 pre");
    rd(A_STS, 8'd100, "R6 max at boundary");
    check("R6 max flag", {31'd0, m_pmax}, 32'd1);
    // R12 unmapped
    wr(12'h02C, 32'hFFFF_FFFF, 8'd100);
    rd(12'h02C, 8'd100, "R12 unmapped read");
    rd(A_CTL, 8'd100, "R12 ctl untouched");
    rd(A_LIM, 8'd100, "R12 lim untouched");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      logic [7:0] lv;
      sel = $urandom_range(0, 9);
      lv = 8'($urandom);
      case (sel)
        0, 1: wr(A_CTL, $urandom | (($urandom_range(0, 3) != 0) ? 32'h0800_0001 : 32'd0), lv);
        2: wr(A_LIM, $urandom, lv);
        3: wr(A_TGT, $urandom, lv);
        4: wr(($urandom_range(0, 1) != 0) ? A_STS : 12'h030, $urandom, lv);
        5: rd(A_CTL, lv, "R2 R4 random ctl");
        6: rd(A_LIM, lv, "R3 random lim");
        default: rd(A_STS, lv, "R5 R6 R9 R10 random sts");
      endcase
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule